// File: doc/BRIEF.md
# Cascadable Serial Configuration Stream Reader

This block is the read side of a bit-serial configuration store. A programmable-logic loader drives its clock and pulls the configuration image out one bit per clock, with no external controller involved. The image sits in an internal array of 8-bit words. A word address counter and a bit-within-word counter walk the array, and each word is sent most significant bit first. The tri-state data pin is modelled as a data value `dout` plus a drive enable `dout_oe`.

A single input, `rst_oe`, does two jobs. Held low, it clears the walk back to bit zero and silences the output. Held high, it enables the output. `ce_n` gates counting, and it also silences the output while it is high. Once the final bit has been sent, the block silences itself and pulls `ceo_n` low, so the next device in a chain can take over the shared data line.

Pulling `ser_en` low selects programming mode. In that mode the walk freezes, the output stays silent whatever `ce_n` does, and a plain word write port fills the array. The array is loaded through that port by the surrounding test environment.

Top module: `cfg_stream_reader`

## Requirements
- R1: After the synchronous power-up reset (`rst_n` low), `dout_oe` is 0, `ceo_n` is 1, and the first bit streamed afterwards is bit 0 of the image.
- R2: While `rst_oe` is low, `dout_oe` is 0 and both counters return to zero, whatever the level of `ce_n`.
- R3: With `ser_en`=1, `rst_oe`=1 and `ce_n`=0, before the terminal count, `dout_oe` is 1 and each rising `clk` edge advances the position by exactly one bit.
- R4: Image bit k appears on `dout` while the position equals k. It is taken from word k/8 at bit index 7-(k mod 8), so each word goes out most significant bit first.
- R5: While `ce_n` is high, `dout_oe` is 0 and the position holds. This includes the time after a reset pulse, until `ce_n` goes low. Streaming then resumes from the held position.
- R6: After bit `CFG_BITS`-1 has been clocked out, `ceo_n` is 0, `dout_oe` is 0, and further clock edges do not move the position.
- R7: Once low, `ceo_n` stays low until a clock edge samples `rst_oe` low (or `rst_n` low), after which it is 1 again.
- R8: With `ser_en` low, `dout_oe` is 0 and the position holds, even with `ce_n`=0 and `rst_oe`=1. Streaming resumes at the held position when `ser_en` returns high.
- R9: A write on `prog_we` stores `prog_data` at word `prog_addr` only when `ser_en` is 0. When `ser_en` is 1, the write has no effect on the array.
- R10: A reset pulse on `rst_oe` in the middle of a stream makes the next streamed bit bit 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader clock; each rising edge may advance the walk |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| ser_en | input | 1 | 1 = read mode, 0 = programming mode |
| ce_n | input | 1 | Active-low chip enable for counting and output |
| rst_oe | input | 1 | Low: clear counters and silence output; high: output enable |
| prog_we | input | 1 | Word write strobe, honoured only in programming mode |
| prog_addr | input | ADDR_W | Word address for a programming write |
| prog_data | input | 8 | Word value for a programming write |
| dout | output | 1 | Current image bit |
| dout_oe | output | 1 | Drive enable of the data pin (0 = high impedance) |
| ceo_n | output | 1 | Active-low cascade output, low after the last bit |

## Verification
The assertions are evaluated on every clock. They check that an enabled output always coincides with a one-bit advance, and that the position holds during standby and in programming mode. They also check that the cascade output stays low until a reset pulse, that it never rises without one, and that the position never passes the last bit. Bit order, the exact data values, the restart at bit zero after a mid-stream pulse, and the ignored write in read mode can only be shown by the bench's scenarios. In those scenarios a reference image is streamed in full and compared bit by bit against a model, and silence is checked in each reset, standby, programming and post-terminal state.

// File: rtl/cfgr_pkg.sv
// Package: shared word type and word-geometry constants for the
// configuration stream reader. Assumes a fixed 8-bit storage word.
package cfgr_pkg;
    localparam int unsigned WORD_BITS = 8;
    localparam int unsigned BIT_IDX_W = $clog2(WORD_BITS);
    typedef logic [WORD_BITS-1:0] cfg_word_t;
    typedef logic [BIT_IDX_W-1:0] bit_idx_t;
endpackage

// File: rtl/cfgr_store.sv
// Module: word array holding the configuration image, with one write
// port and a combinational single-bit read port (MSB of a word first).
// Assumes rd_addr never exceeds WORDS-1 and wr_en is pre-qualified.
module cfgr_store
    import cfgr_pkg::*;
#(
    parameter int unsigned WORDS  = 126,
    parameter int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  cfg_word_t         wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  bit_idx_t          rd_bit,
    output logic              rd_val
);
    localparam bit_idx_t TOP_IDX = bit_idx_t'(WORD_BITS - 1);

    cfg_word_t mem [WORDS];
    cfg_word_t rd_word;

    // Store one word per qualified write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Select the addressed bit, counting from the word's MSB.
    always_comb begin
        rd_word = mem[rd_addr];
        rd_val  = rd_word[TOP_IDX - rd_bit];
    end
endmodule

// File: rtl/cfgr_walker.sv
// Module: word-address and bit-within-word counters plus the terminal
// flag. Clears on power-up reset or on clear; advances on step_en until
// the last bit has been clocked, then freezes with done_q set.
module cfgr_walker
    import cfgr_pkg::*;
#(
    parameter int unsigned CFG_BITS = 1003,
    parameter int unsigned ADDR_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step_en,
    output logic [ADDR_W-1:0] word_q,
    output bit_idx_t          bit_q,
    output logic              done_q
);
    localparam int unsigned LAST_POS  = CFG_BITS - 1;
    localparam int unsigned LAST_WORD = LAST_POS / WORD_BITS;
    localparam int unsigned LAST_BIT  = LAST_POS % WORD_BITS;
    localparam bit_idx_t    TOP_IDX   = bit_idx_t'(WORD_BITS - 1);

    logic at_last;

    // Flag the final position of the image.
    always_comb begin
        at_last = (word_q == ADDR_W'(LAST_WORD)) && (bit_q == bit_idx_t'(LAST_BIT));
    end

    // Walk the image one bit per enabled clock; stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_q <= '0;
            bit_q  <= '0;
            done_q <= 1'b0;
        end else if (step_en && !done_q) begin
            if (at_last) begin
                done_q <= 1'b1;
            end else if (bit_q == TOP_IDX) begin
                bit_q  <= '0;
                word_q <= word_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgr_gate.sv
// Module: mode and enable decode. Derives the count enable, the data
// drive enable and the cascade output from the pins and terminal flag.
// Assumes all inputs are already synchronous to the loader clock.
module cfgr_gate (
    input  logic ser_en,
    input  logic rst_oe,
    input  logic ce_n,
    input  logic done,
    output logic step_en,
    output logic drive_en,
    output logic casc_n
);
    // Count only in read mode, out of reset, with the chip enabled.
    always_comb begin
        step_en  = ser_en && rst_oe && !ce_n;
        drive_en = step_en && !done;
        casc_n   = !done;
    end
endmodule

// File: rtl/cfg_stream_reader.sv
// Module: top of the cascadable serial configuration stream reader.
// Streams CFG_BITS bits MSB-first from an 8-bit word array, gated by
// ce_n and the dual-role rst_oe pin; signals hand-over on ceo_n.
// Assumes rst_n is a synchronous power-up reset.
module cfg_stream_reader
    import cfgr_pkg::*;
#(
    parameter int unsigned CFG_BITS = 1003,
    parameter int unsigned WORDS    = (CFG_BITS + WORD_BITS - 1) / WORD_BITS,
    parameter int unsigned ADDR_W   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ce_n,
    input  logic              rst_oe,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    output logic              dout,
    output logic              dout_oe,
    output logic              ceo_n
);
    localparam int unsigned POS_W = ADDR_W + BIT_IDX_W;

    logic [ADDR_W-1:0] word_q;
    bit_idx_t          bit_q;
    logic              done_q;
    logic              step_en;
    logic              wr_ok;
    logic [POS_W-1:0]  pos_w;

    // Writes are honoured only in programming mode.
    always_comb begin
        wr_ok = prog_we && !ser_en;
        pos_w = {word_q, bit_q};
    end

    cfgr_gate u_gate (
        .ser_en  (ser_en),
        .rst_oe  (rst_oe),
        .ce_n    (ce_n),
        .done    (done_q),
        .step_en (step_en),
        .drive_en(dout_oe),
        .casc_n  (ceo_n)
    );

    cfgr_walker #(.CFG_BITS(CFG_BITS), .ADDR_W(ADDR_W)) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!rst_oe),
        .step_en(step_en),
        .word_q (word_q),
        .bit_q  (bit_q),
        .done_q (done_q)
    );

    cfgr_store #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .wr_en  (wr_ok),
        .wr_addr(prog_addr),
        .wr_data(prog_data),
        .rd_addr(word_q),
        .rd_bit (bit_q),
        .rd_val (dout)
    );
endmodule

// File: rtl/cfg_stream_reader_chk.sv
// Module: checker bound to cfg_stream_reader. Watches the pins and the
// walk position for the cycle-by-cycle rules of the stream.
module cfg_stream_reader_chk #(
    parameter int unsigned POS_W    = 10,
    parameter int unsigned LAST_POS = 1002
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_en,
    input logic             ce_n,
    input logic             rst_oe,
    input logic             dout_oe,
    input logic             ceo_n,
    input logic [POS_W-1:0] pos
);
    AST_DRIVE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |=> (pos == POS_W'($past(pos) + 1'b1)) || !ceo_n); // R3
    AST_STANDBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_oe && ce_n) |=> $stable(pos)); // R5
    AST_PROG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_oe && !ser_en) |=> $stable(pos)); // R8
    AST_CASCADE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n |-> !dout_oe); // R6
    AST_POS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_W'(LAST_POS)); // R6
    AST_CASCADE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ceo_n && rst_oe) |=> !ceo_n); // R7
    AST_CASCADE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ceo_n) |-> $past(!rst_oe)); // R7
    AST_RESET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_oe |=> (pos == '0)); // R2
endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(
    .POS_W   (ADDR_W + 3),
    .LAST_POS(CFG_BITS - 1)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_en (ser_en),
    .ce_n   (ce_n),
    .rst_oe (rst_oe),
    .dout_oe(dout_oe),
    .ceo_n  (ceo_n),
    .pos    (pos_w)
);

// File: tb/sim_cfg_stream_reader.sv
// Bench: scoreboard. The stream task queues expected bits from a model
// image; a negedge monitor pops and compares whenever the pin is driven.
module sim_cfg_stream_reader;
    localparam int CFG_BITS = 1003;
    localparam int WORDS    = (CFG_BITS + 7) / 8;
    localparam int ADDR_W   = $clog2(WORDS);
    localparam time CYC     = 8ns;

    logic              clk = 1'b0;
    logic              rst_n, ser_en, ce_n, rst_oe, prog_we;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;
    logic              dout, dout_oe, ceo_n;

    logic [7:0] model [WORDS];
    bit         exp_q [$];
    int         exp_pos = 0;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #(CYC / 2) clk = ~clk;

    cfg_stream_reader #(.CFG_BITS(CFG_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ce_n), .rst_oe(rst_oe),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .dout(dout), .dout_oe(dout_oe), .ceo_n(ceo_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int p);
        logic [7:0] w;
        w = model[p / 8];
        return w[7 - (p % 8)];
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // R3 / R4: queue expected bits, one per enabled clock.
    task automatic stream(input int n);
        ser_en = 1'b1; rst_oe = 1'b1; ce_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp_bit(exp_pos));
            exp_pos++;
            step();
        end
        ce_n = 1'b1;
        check(exp_q.size() == 0, "R3 bits not driven", exp_q.size(), 0);
    endtask

    // Samples silence at the next negedge, then returns to the drive point.
    task automatic quiet(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(dout_oe === 1'b0, tag, int'(dout_oe), 0);
            step();
        end
    endtask

    // Monitor: compare every driven bit against the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && dout_oe === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected drive", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(dout === e, "R4 stream bit", int'(dout), int'(e));
            end
        end
    end

    initial begin
        #(CYC * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ser_en = 1'b1; ce_n = 1'b1; rst_oe = 1'b1;
        prog_we = 1'b0; prog_addr = '0; prog_data = '0;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_oe === 1'b0, "R1 oe after reset", int'(dout_oe), 0);
        check(ceo_n === 1'b1, "R1 ceo_n after reset", int'(ceo_n), 1);
        step();

        // R8 / R9: program the image with ce_n low; output must stay silent.
        ser_en = 1'b0; ce_n = 1'b0;
        for (int w = 0; w < WORDS; w++) begin
            model[w]  = 8'((w * 37 + 5) ^ (w >> 2));
            prog_addr = ADDR_W'(w);
            prog_data = model[w];
            prog_we   = 1'b1;
            @(negedge clk);
            check(dout_oe === 1'b0, "R8 silent in programming", int'(dout_oe), 0);
            step();
        end
        prog_we = 1'b0;
        ser_en = 1'b1; ce_n = 1'b1;
        step();

        // R9: a write attempt in read mode must not alter word 1.
        prog_addr = ADDR_W'(1); prog_data = ~model[1]; prog_we = 1'b1;
        step();
        prog_we = 1'b0;

        // R1: first bit after power-up is bit 0; R4 order through 20 bits.
        stream(20);
        quiet("R5 standby silent", 4);
        stream(30);                       // R5: resumes at bit 20

        // R8: programming mode mid-stream holds the position.
        ce_n = 1'b0; rst_oe = 1'b1; ser_en = 1'b0;
        quiet("R8 mid-stream hold", 3);
        stream(10);                       // continues at bit 50

        // R2 / R10: reset pulse with ce_n low, then restart from bit 0.
        ce_n = 1'b0; rst_oe = 1'b0;
        quiet("R2 reset silences", 2);
        rst_oe = 1'b1;
        exp_pos = 0;
        stream(16);

        // R2 with ce_n high, then R5: stays disabled until ce_n falls.
        ce_n = 1'b1; rst_oe = 1'b0;
        step();
        rst_oe = 1'b1;
        quiet("R5 disabled after reset pulse", 3);
        exp_pos = 0;
        stream(CFG_BITS);                 // full image, includes R9 word

        // R6: terminal count reached.
        ce_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(dout_oe === 1'b0, "R6 silent after last bit", int'(dout_oe), 0);
            check(ceo_n === 1'b0, "R6 cascade low", int'(ceo_n), 0);
            step();
        end

        // R7: ce_n toggling keeps ceo_n low; rst_oe low releases it.
        ce_n = 1'b1;
        step();
        ce_n = 1'b0;
        @(negedge clk);
        check(ceo_n === 1'b0, "R7 cascade held", int'(ceo_n), 0);
        step();
        rst_oe = 1'b0;
        step();
        @(negedge clk);
        check(ceo_n === 1'b1, "R7 cascade released", int'(ceo_n), 1);
        check(dout_oe === 1'b0, "R2 silent in reset", int'(dout_oe), 0);
        step();
        exp_pos = 0;
        stream(12);                       // R10: restarts at bit 0

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule